// File: doc/BRIEF.md
# Indirect Port Attribute Access Window

This block lets a host reach a large set of per-port attribute registers through two byte-wide access points. The host first writes a select byte that names a port and an attribute. Each access to the data point then moves one byte of that attribute, starting with the least significant byte.

Reads are served from a holding copy of the attribute. The copy is taken on the first byte read and taken again after the final byte, so a multi-byte value always arrives as one consistent snapshot. The two six-byte source-address attributes can also be written. Their stored value changes only when six consecutive byte writes complete. Any interruption leaves the old value in place.

The attribute store is modelled inside the block. Read-only attributes hold fixed values. The writable ones start from the same pattern at reset.

Top module: `attr_window`

## Requirements
- R1: While reset is asserted, and directly after it, `dat_dout` is 0.
- R2: A select write loads `sel_din[7:4]` as the port index and `sel_din[3:0]` as the attribute index. Port indices 0–11 are data ports, 12–14 are three service ports and 15 names no port. Attributes 0–5 are read-only and 4 bytes wide, attributes 6 and 7 are writable and 6 bytes wide, and 8–15 name no attribute. Every select write restarts the sequence at byte 0.
- R3: A read strobe places the next byte on `dat_dout` one cycle later. Bytes come out least significant first, and `dat_dout` changes only after a read strobe.
- R4: For a read-only attribute, the read after byte 3 returns byte 0 of a freshly taken copy.
- R5: For a writable attribute, the read after byte 5 returns byte 0 of a freshly taken copy.
- R6: After reset, byte k of attribute a of port p holds (32·p + 4·a + k) mod 256.
- R7: Six consecutive byte writes to a writable attribute replace its value with those bytes, least significant first. A read after that returns the new value.
- R8: A select write that comes before the sixth write byte leaves the stored value unchanged.
- R9: A read that comes in the middle of a partial write leaves the stored value unchanged and returns byte 0.
- R10: Byte writes to a read-only or non-existent attribute change nothing and do not advance the byte position.
- R11: When the port or attribute index names nothing, every read returns 0.
- R12: A select write in the same cycle as a data strobe wins, and the strobe is dropped. When read and write strobes arrive together, only the read takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_din | input | 8 | Select byte: port index [7:4], attribute index [3:0] |
| dat_rd | input | 1 | Data read strobe |
| dat_wr | input | 1 | Data write strobe |
| dat_din | input | 8 | Data write byte |
| dat_dout | output | 8 | Data read byte, valid the cycle after `dat_rd` |

## Verification
The bench sweeps all 256 select values and reads past the end of each attribute. A wrong wrap point would show up as a byte from a stale copy or the wrong width, and a bad invalid decode would leak non-zero data. Write sequences are cut short by a select write and by a read. A design that committed early, or kept a partial buffer, would alter the stored address. The bench also issues writes to read-only attributes between reads, which catches a counter that advances when it should not. It drives simultaneous strobes to show that a dropped strobe has no effect on the byte position or on a later write.

// File: rtl/attr_window.sv
module attr_window #(
  parameter int NPORT = 15,
  parameter int NATTR = 8,
  parameter int RW_A  = 6,
  parameter int RW_B  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_wr,
  input  logic [7:0] sel_din,
  input  logic       dat_rd,
  input  logic       dat_wr,
  input  logic [7:0] dat_din,
  output logic [7:0] dat_dout
);
  localparam logic [3:0] NP   = 4'(NPORT);
  localparam logic [3:0] NA   = 4'(NATTR);
  localparam logic [3:0] RWA  = 4'(RW_A);
  localparam logic [3:0] RWB  = 4'(RW_B);
  localparam logic [2:0] LAST_RO = 3'd3;
  localparam logic [2:0] LAST_RW = 3'd5;

  function automatic logic [47:0] init_val(input int p, input int a);
    logic [47:0] v;
    for (int k = 0; k < 6; k++) v[8*k +: 8] = 8'(p*32 + a*4 + k);
    return v;
  endfunction

  logic [3:0]  port_q, attr_q;
  logic [2:0]  idx;
  logic        wmode;
  logic [47:0] hold, wbuf;
  logic [7:0]  dout_q;
  logic [47:0] rw_mem [NPORT][2];

  logic        valid, is_rw, rw_sel;
  logic [3:0]  pidx;
  logic [2:0]  last, rd_idx, wr_idx;
  logic [47:0] live, rd_src;

  assign valid  = (port_q < NP) && (attr_q < NA);
  assign is_rw  = (attr_q == RWA) || (attr_q == RWB);
  assign rw_sel = (attr_q == RWB);
  assign pidx   = valid ? port_q : 4'd0;
  assign last   = is_rw ? LAST_RW : LAST_RO;
  assign rd_idx = wmode ? 3'd0 : idx;
  assign wr_idx = wmode ? idx : 3'd0;

  always_comb begin
    if (!valid)     live = '0;
    else if (is_rw) live = rw_mem[pidx][rw_sel];
    else            live = {16'h0, init_val(int'(pidx), int'(attr_q)) >> 0}[47:0] & 48'h0000_FFFF_FFFF;
  end

  assign rd_src   = (rd_idx == 3'd0) ? live : hold;
  assign dat_dout = dout_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      port_q <= '0;
      attr_q <= '0;
      idx    <= '0;
      wmode  <= 1'b0;
      hold   <= '0;
      wbuf   <= '0;
      dout_q <= '0;
      for (int p = 0; p < NPORT; p++) begin
        rw_mem[p][0] <= init_val(p, RW_A);
        rw_mem[p][1] <= init_val(p, RW_B);
      end
    end else if (sel_wr) begin
      port_q <= sel_din[7:4];
      attr_q <= sel_din[3:0];
      idx    <= '0;
      wmode  <= 1'b0;
    end else if (dat_rd) begin
      dout_q <= rd_src[{rd_idx, 3'b000} +: 8];
      if (rd_idx == 3'd0) hold <= live;
      idx    <= (rd_idx == last) ? 3'd0 : rd_idx + 3'd1;
      wmode  <= 1'b0;
    end else if (dat_wr && valid && is_rw) begin
      wmode <= 1'b1;
      if (wr_idx == LAST_RW) begin
        rw_mem[pidx][rw_sel] <= {dat_din, wbuf[39:0]};
        idx <= '0;
      end else begin
        wbuf[{wr_idx, 3'b000} +: 8] <= dat_din;
        idx <= wr_idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/attr_window_chk.sv
module attr_window_chk #(
  parameter int NPORT = 15,
  parameter int NATTR = 8,
  parameter int RW_A  = 6,
  parameter int RW_B  = 7
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_wr,
  input logic [7:0] sel_din,
  input logic       dat_rd,
  input logic       dat_wr,
  input logic [7:0] dat_dout,
  input logic [2:0] idx,
  input logic       wmode
);
  localparam logic [3:0] NP  = 4'(NPORT);
  localparam logic [3:0] NA  = 4'(NATTR);
  localparam logic [3:0] RWA = 4'(RW_A);
  localparam logic [3:0] RWB = 4'(RW_B);

  logic [3:0] cport, cattr;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cport <= '0;
      cattr <= '0;
    end else if (sel_wr) begin
      cport <= sel_din[7:4];
      cattr <= sel_din[3:0];
    end
  end

  logic c_ok, c_rw;
  assign c_ok = (cport < NP) && (cattr < NA);
  assign c_rw = (cattr == RWA) || (cattr == RWB);

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> dat_dout == 8'h00);

  p_sel_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (idx == 3'd0) && !wmode);

  p_dout_only_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_rd && !sel_wr) |=> $stable(dat_dout));

  p_ro_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !sel_wr && c_ok && !c_rw && !wmode && idx == 3'd3) |=> idx == 3'd0);

  p_idx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) idx <= 3'd5);

  p_ignore_ro_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !dat_rd && !sel_wr && !(c_ok && c_rw)) |=> $stable(idx) && $stable(wmode));

  p_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !sel_wr && !c_ok) |=> dat_dout == 8'h00);
endmodule

bind attr_window attr_window_chk #(.NPORT(NPORT), .NATTR(NATTR), .RW_A(RW_A), .RW_B(RW_B)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_din(sel_din), .dat_rd(dat_rd),
  .dat_wr(dat_wr), .dat_dout(dat_dout), .idx(idx), .wmode(wmode)
);

// File: tb/tb_attr_window.sv
module tb_attr_window;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_wr = 1'b0;
  logic [7:0] sel_din = '0;
  logic       dat_rd = 1'b0;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_din = '0;
  logic [7:0] dat_dout;

  int checks = 0;
  int fails  = 0;
  logic [47:0] sh [16][2];

  always #2 clk = ~clk;

  attr_window dut (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_din(sel_din),
    .dat_rd(dat_rd), .dat_wr(dat_wr), .dat_din(dat_din), .dat_dout(dat_dout)
  );

  function automatic logic [7:0] fmt(input int p, input int a, input int k);
    return 8'(p*32 + a*4 + k);
  endfunction

  function automatic logic [7:0] expect_byte(input int p, input int a, input int k);
    if (p > 14 || a > 7) return 8'h00;
    if (a >= 6) return sh[p][a-6][8*k +: 8];
    return fmt(p, a, k);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_sel(input int p, input int a);
    @(negedge clk);
    sel_wr = 1'b1; sel_din = {4'(p), 4'(a)};
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic do_rd(output logic [7:0] b);
    @(negedge clk);
    dat_rd = 1'b1;
    @(negedge clk);
    dat_rd = 1'b0;
    b = dat_dout;
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk);
    dat_wr = 1'b1; dat_din = b;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic full_wr(input int p, input int a, input logic [47:0] v);
    do_sel(p, a);
    for (int k = 0; k < 6; k++) do_wr(v[8*k +: 8]);
  endtask

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog: got hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [47:0] v;
    for (int p = 0; p < 16; p++)
      for (int j = 0; j < 2; j++)
        for (int k = 0; k < 6; k++) sh[p][j][8*k +: 8] = fmt(p, 6 + j, k);

    repeat (3) @(negedge clk);
    chk("R1 reset output", dat_dout, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", dat_dout, 8'h00);

    // R2 R3 R4 R5 R6 R11: sweep every select value, read past the wrap point
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 16; a++) begin
        int w;
        w = (a >= 6 && a <= 7) ? 6 : 4;
        do_sel(p, a);
        for (int n = 0; n < w + 2; n++) begin
          do_rd(b);
          chk((p > 14 || a > 7) ? "R11 invalid zero" : (w == 6 ? "R5 R6 rw read" : "R4 R6 ro read"),
              b, expect_byte(p, a, n % w));
        end
      end

    // R7: full writes to both writable attributes over several ports
    for (int p = 0; p < 15; p += 3)
      for (int a = 6; a < 8; a++) begin
        for (int k = 0; k < 6; k++) v[8*k +: 8] = 8'(p*7 + a*13 + k*29 + 1);
        full_wr(p, a, v);
        sh[p][a-6] = v;
        do_sel(p, a);
        for (int k = 0; k < 7; k++) begin
          do_rd(b);
          chk("R7 commit readback", b, expect_byte(p, a, k % 6));
        end
      end

    // R8: partial write aborted by select
    do_sel(5, 6);
    for (int k = 0; k < 5; k++) do_wr(8'hC0 + 8'(k));
    do_sel(5, 6);
    for (int k = 0; k < 6; k++) begin
      do_rd(b);
      chk("R8 abort by select", b, expect_byte(5, 6, k));
    end

    // R9: partial write aborted by read
    do_sel(8, 7);
    for (int k = 0; k < 4; k++) do_wr(8'h5A);
    do_rd(b);
    chk("R9 read aborts write byte0", b, expect_byte(8, 7, 0));
    for (int k = 1; k < 6; k++) begin
      do_rd(b);
      chk("R9 old value kept", b, expect_byte(8, 7, k));
    end
    do_wr(8'h11);
    do_wr(8'h22);
    do_sel(8, 7);
    do_rd(b);
    chk("R9 two-byte write not committed", b, expect_byte(8, 7, 0));

    // R10: writes to read-only and invalid attributes
    do_sel(9, 2);
    do_rd(b);
    chk("R10 ro byte0", b, expect_byte(9, 2, 0));
    do_wr(8'hEE);
    do_wr(8'hEE);
    do_rd(b);
    chk("R10 ro write ignored", b, expect_byte(9, 2, 1));
    do_sel(15, 6);
    for (int k = 0; k < 6; k++) do_wr(8'h77);
    do_rd(b);
    chk("R10 invalid write ignored", b, 8'h00);

    // R12: select beats read strobe
    do_sel(2, 6);
    do_rd(b);
    chk("R12 prep byte0", b, expect_byte(2, 6, 0));
    @(negedge clk);
    sel_wr = 1'b1; sel_din = 8'h30; dat_rd = 1'b1;
    @(negedge clk);
    sel_wr = 1'b0; dat_rd = 1'b0;
    chk("R12 read dropped under select", dat_dout, expect_byte(2, 6, 0));
    do_rd(b);
    chk("R12 new select byte0", b, expect_byte(3, 0, 0));

    // R12: read beats write
    do_sel(4, 7);
    @(negedge clk);
    dat_rd = 1'b1; dat_wr = 1'b1; dat_din = 8'hAA;
    @(negedge clk);
    dat_rd = 1'b0; dat_wr = 1'b0;
    chk("R12 read wins over write", dat_dout, expect_byte(4, 7, 0));
    v = 48'h0605_0403_0201;
    for (int k = 0; k < 6; k++) do_wr(v[8*k +: 8]);
    sh[4][1] = v;
    do_sel(4, 7);
    for (int k = 0; k < 6; k++) begin
      do_rd(b);
      chk("R12 dropped write not counted", b, expect_byte(4, 7, k));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule